// File: doc/BRIEF.md
# Receive Silo with Fill Alarm

This block is the shared receive queue of an eight-line asynchronous serial multiplexer. Each serial receiver hands over a finished character together with its line number and its parity, framing and overrun flags. The silo stores these entries in arrival order and always presents the oldest one as a 16-bit read word. Software pops the silo by reading that word. Each read removes one entry. After a read, the next entry appears only once a short settling window has passed.

Two status flags come out of the block. The done flag shows that a valid word sits at the output. The alarm flag rises once sixteen characters have arrived since the last read. The alarm counts arrivals, not occupancy. A receive interrupt request is formed from either flag, chosen by two enable bits that software writes through a small control strobe. A scan-enable input gates the whole receive path. A synchronous clear empties the queue and drops both enables. A write that finds the queue full is discarded and reported with a one-cycle overflow pulse.

Top module: `rx_silo`

## Requirements
- R1: The read word carries the character in bits 7:0, the line number in bits 10:8, a constant 0 in bit 11, the parity error in bit 12, the framing error in bit 13, the overrun flag in bit 14 and the valid bit in bit 15. Characters shorter than 8 bits arrive with their high bits at zero and are passed through unchanged.
- R2: Entries leave in the order they were accepted, and each read of a valid word removes exactly one entry.
- R3: A read while the silo is empty returns a word with bit 15 equal to 0 and removes nothing.
- R4: After any read, bit 15 of the read word stays 0 for SETTLE_CYC clock cycles (default 4). The next entry becomes visible in the cycle that follows.
- R5: `done` is 1 exactly when the read word holds a valid entry. It drops after a read and returns when the next entry reaches the output.
- R6: `alarm` sets on the 16th character accepted since the last read or clear. A read clears both the alarm and its count, and a further 16 arrivals are needed to set it again.
- R7: With the receive interrupt enable at 1 and the alarm enable at 0, `irq` follows `done`. With both enables at 1, `irq` follows `alarm` only. With the receive interrupt enable at 0, `irq` stays 0.
- R8: While `scan_en` is 0, the silo is held empty, incoming characters are discarded and bit 15 of the read word is 0.
- R9: `clr` empties the silo, clears the valid bit and resets both interrupt enables to 0. It does not force bits 14:0 of the read word to zero.
- R10: The silo holds DEPTH entries (default 64). A write into a full silo is dropped, leaves the stored entries unchanged, and raises `ovf_pulse` for one cycle in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Enables the receive path. At 0 the silo is held empty |
| clr | input | 1 | Synchronous clear of the silo, the alarm and the enables |
| ctl_wr | input | 1 | Loads the two interrupt enable bits |
| ctl_rie | input | 1 | Receive interrupt enable value, taken on `ctl_wr` |
| ctl_sae | input | 1 | Alarm enable value, taken on `ctl_wr` |
| wr_en | input | 1 | Strobe offering one received character |
| wr_char | input | 8 | Received character, right-justified |
| wr_line | input | 3 | Line number the character came from |
| wr_perr | input | 1 | Parity error flag |
| wr_ferr | input | 1 | Framing error flag |
| wr_ovr | input | 1 | Receiver overrun flag |
| rd_en | input | 1 | Read strobe. Pops the presented entry |
| rd_word | output | 16 | Oldest entry in read-word layout |
| done | output | 1 | A valid word is presented |
| alarm | output | 1 | Sixteen arrivals since the last read |
| irq | output | 1 | Receive interrupt request |
| rie_o | output | 1 | Current receive interrupt enable |
| sae_o | output | 1 | Current alarm enable |
| ovf_pulse | output | 1 | One-cycle pulse for a write dropped on a full silo |

## Verification
The in-line assertions watch several properties on every cycle. The occupancy never exceeds the depth, and no push reaches a full queue. No pop happens on an empty queue. The output blanks in the cycle after each read. A read always leaves the alarm clear, and the alarm only rises after an accepted push. The interrupt stays quiet in alarm mode until the alarm is set. Scan-off and clear both leave no valid word behind. The directed scenarios cover what a per-cycle property cannot show: the exact bit layout of a stored entry, first-in first-out order across a full 64-entry fill and drain, the alarm firing on precisely the 16th arrival rather than the 15th, the length of the settling window, and stored contents surviving a dropped write.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  localparam int CHAR_W = 8;
  localparam int LINE_W = 3;
  localparam int WORD_W = 16;

  // One stored entry: flags above line number above character.
  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  // Build the read word: valid, three flags, a zero spacer, line, char.
  function automatic logic [WORD_W-1:0] pack_word(input logic valid,
                                                  input rx_entry_t e);
    return {valid, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.ch};
  endfunction

endpackage

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t entry_in,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  rx_entry_t     mem [DEPTH];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Next-state for pointers and occupancy; flush wins over everything.
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = bump(wptr_q);
      if (pop)  rptr_d = bump(rptr_q);
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage array: no reset, written only on an accepted push.
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= entry_in;
  end

  assign head  = mem[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CAP);

  // R10: occupancy never passes the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  // R10: the control logic never pushes into a full queue
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: nothing is popped from an empty queue
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/rx_silo_settle.sv
module rx_silo_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  output logic busy
);

  localparam int TW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [TW-1:0] LOAD = TW'(SETTLE_CYC);

  logic [TW-1:0] tmr_q, tmr_d;

  // Each read reloads the blanking timer; otherwise count down to zero.
  always_comb begin
    tmr_d = tmr_q;
    if (rd)                tmr_d = LOAD;
    else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign busy = (tmr_q != '0);

  generate
    if (SETTLE_CYC > 0) begin : g_chk
      // R4: the cycle after a read is always blanked
      a_r4_blank_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> busy);
    end
  endgenerate

endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
  parameter int ALARM_AT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic rd,
  output logic alarm
);

  localparam int AW = (ALARM_AT > 1) ? $clog2(ALARM_AT) : 1;
  localparam logic [AW-1:0] TOP = AW'(ALARM_AT - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          alm_q, alm_d;

  // Arrivals since the last read; wraps to zero when the alarm fires.
  always_comb begin
    cnt_d = cnt_q;
    alm_d = alm_q;
    if (flush) begin
      cnt_d = '0;
      alm_d = 1'b0;
    end else if (rd) begin
      cnt_d = push ? AW'(1) : '0;
      alm_d = 1'b0;
    end else if (push) begin
      if (cnt_q == TOP) begin
        cnt_d = '0;
        alm_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      alm_q <= alm_d;
    end
  end

  assign alarm = alm_q;

  // R6: a read leaves the alarm clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !alarm);
  // R6: the alarm only rises after an accepted arrival
  a_r6_rise_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(push));

endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int SETTLE_CYC = 4,
  parameter int ALARM_AT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              clr,
  input  logic              ctl_wr,
  input  logic              ctl_rie,
  input  logic              ctl_sae,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              wr_ovr,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              done,
  output logic              alarm,
  output logic              irq,
  output logic              rie_o,
  output logic              sae_o,
  output logic              ovf_pulse
);

  rx_entry_t entry_in, head;
  logic      empty, full, busy;
  logic      flush, offer, push, drop, pop, valid;
  logic      rie_q, rie_d, sae_q, sae_d, ovf_q;

  assign entry_in = '{ovr: wr_ovr, ferr: wr_ferr, perr: wr_perr,
                      line: wr_line, ch: wr_char};

  // Scan-off or clear hold the queue empty.
  assign flush = clr | ~scan_en;
  assign offer = wr_en & ~flush;
  assign push  = offer & ~full;
  assign drop  = offer & full;
  assign valid = scan_en & ~empty & ~busy;
  assign pop   = rd_en & valid;

  rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (push),
    .entry_in (entry_in),
    .pop      (pop),
    .head     (head),
    .empty    (empty),
    .full     (full)
  );

  rx_silo_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (rd_en),
    .busy  (busy)
  );

  rx_silo_alarm #(.ALARM_AT(ALARM_AT)) u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .rd    (rd_en),
    .alarm (alarm)
  );

  // Interrupt enables: clear wins over a control write.
  always_comb begin
    rie_d = rie_q;
    sae_d = sae_q;
    if (clr) begin
      rie_d = 1'b0;
      sae_d = 1'b0;
    end else if (ctl_wr) begin
      rie_d = ctl_rie;
      sae_d = ctl_sae;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie_q <= 1'b0;
      sae_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      rie_q <= rie_d;
      sae_q <= sae_d;
      ovf_q <= drop;
    end
  end

  assign rd_word   = pack_word(valid, head);
  assign done      = valid;
  assign irq       = rie_q & (sae_q ? alarm : valid);
  assign rie_o     = rie_q;
  assign sae_o     = sae_q;
  assign ovf_pulse = ovf_q;

  // R7: in alarm mode nothing requests service until the alarm is up
  a_r7_alarm_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sae_q && !alarm) |-> !irq);
  // R8: scan disabled leaves no valid word in the next cycle
  a_r8_scan_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !done);
  // R9: clear drops the enables and the valid word
  a_r9_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rie_o && !sae_o && !rd_word[15]));
  // R10: an overflow pulse always follows an offered write
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(wr_en));

endmodule

// File: tb/rx_silo_tb.sv
`timescale 1ns/1ps
module rx_silo_tb;

  localparam int DEPTH  = 64;
  localparam int SETTLE = 4;
  localparam int ALM    = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en, clr, ctl_wr, ctl_rie, ctl_sae;
  logic        wr_en, wr_perr, wr_ferr, wr_ovr, rd_en;
  logic [7:0]  wr_char;
  logic [2:0]  wr_line;
  logic [15:0] rd_word;
  logic        done, alarm, irq, rie_o, sae_o, ovf_pulse;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  rx_silo #(.DEPTH(DEPTH), .SETTLE_CYC(SETTLE), .ALARM_AT(ALM)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clr(clr),
    .ctl_wr(ctl_wr), .ctl_rie(ctl_rie), .ctl_sae(ctl_sae),
    .wr_en(wr_en), .wr_char(wr_char), .wr_line(wr_line),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_ovr(wr_ovr),
    .rd_en(rd_en), .rd_word(rd_word), .done(done), .alarm(alarm),
    .irq(irq), .rie_o(rie_o), .sae_o(sae_o), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // All helpers start and end on a falling edge.
  task automatic push(input logic [7:0] c, input logic [2:0] l,
                      input logic p, input logic f, input logic o);
    wr_char = c; wr_line = l; wr_perr = p; wr_ferr = f; wr_ovr = o;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(output logic [15:0] w);
    w = rd_word;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle_wait();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic set_ctl(input logic r, input logic s);
    ctl_rie = r; ctl_sae = s; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R5 reset done", done, 0);
    check("R3 reset word valid", rd_word[15], 0);
    check("R6 reset alarm", alarm, 0);
    check("R7 reset irq", irq, 0);
  endtask

  task automatic t_layout();
    logic [15:0] w;
    push(8'hA5, 3'd5, 1'b1, 1'b0, 1'b1);
    check("R1 layout flags", rd_word, 16'hD5A5);
    check("R5 done set", done, 1);
    do_read(w);
    check("R1 read returns word", w, 16'hD5A5);
    check("R5 done clears after read", done, 0);
    settle_wait();
    check("R3 empty word invalid", rd_word[15], 0);
    do_read(w);
    check("R3 empty read returns invalid", w[15], 0);
    settle_wait();
    push(8'h1F, 3'd0, 1'b0, 1'b1, 1'b0);
    check("R1 short char and ferr", rd_word, 16'hA01F);
    do_read(w);
    settle_wait();
    check("R3 empty after single pop", rd_word[15], 0);
  endtask

  task automatic t_order_settle();
    logic [15:0] w;
    push(8'h10, 3'd1, 1'b0, 1'b0, 1'b0);
    push(8'h11, 3'd2, 1'b0, 1'b0, 1'b0);
    push(8'h12, 3'd3, 1'b0, 1'b0, 1'b0);
    do_read(w);
    check("R2 first out", w, 16'h8110);
    for (int k = 0; k < SETTLE; k++) begin
      check("R4 blank during settle", rd_word[15], 0);
      @(negedge clk);
    end
    check("R4 visible after settle", rd_word, 16'h8211);
    check("R5 done returns", done, 1);
    do_read(w);
    settle_wait();
    do_read(w);
    check("R2 third out", w, 16'h8312);
    settle_wait();
    check("R2 drained", done, 0);
  endtask

  task automatic t_irq_modes();
    do_clear();
    set_ctl(1'b1, 1'b0);
    push(8'h41, 3'd4, 1'b0, 1'b0, 1'b0);
    check("R7 irq follows done", irq, 1);
    set_ctl(1'b0, 1'b0);
    check("R7 rie off no irq", irq, 0);
    check("R5 done still set", done, 1);
    set_ctl(1'b1, 1'b1);
    check("R7 alarm mode ignores done", irq, 0);
  endtask

  task automatic t_alarm();
    logic [15:0] w;
    do_clear();
    set_ctl(1'b1, 1'b1);
    for (int i = 0; i < ALM - 1; i++) push(8'(i), 3'd6, 1'b0, 1'b0, 1'b0);
    check("R6 no alarm at 15", alarm, 0);
    check("R7 no irq before alarm", irq, 0);
    push(8'hF0, 3'd6, 1'b0, 1'b0, 1'b0);
    check("R6 alarm at 16", alarm, 1);
    check("R7 irq from alarm", irq, 1);
    do_read(w);
    check("R6 read clears alarm", alarm, 0);
    check("R7 irq drops with alarm", irq, 0);
    settle_wait();
    for (int i = 0; i < ALM - 1; i++) push(8'(i), 3'd7, 1'b0, 1'b0, 1'b0);
    check("R6 count restarted", alarm, 0);
    push(8'hF1, 3'd7, 1'b0, 1'b0, 1'b0);
    check("R6 alarm again after 16", alarm, 1);
  endtask

  task automatic t_scan();
    do_clear();
    push(8'h21, 3'd1, 1'b0, 1'b0, 1'b0);
    push(8'h22, 3'd1, 1'b0, 1'b0, 1'b0);
    scan_en = 1'b0;
    @(negedge clk);
    check("R8 scan off done", done, 0);
    check("R8 scan off word invalid", rd_word[15], 0);
    push(8'h23, 3'd1, 1'b0, 1'b0, 1'b0);
    check("R8 write ignored while off", done, 0);
    scan_en = 1'b1;
    @(negedge clk);
    check("R8 silo empty after scan on", done, 0);
  endtask

  task automatic t_clear();
    set_ctl(1'b1, 1'b1);
    push(8'h31, 3'd2, 1'b0, 1'b0, 1'b0);
    push(8'h32, 3'd2, 1'b0, 1'b0, 1'b0);
    do_clear();
    check("R9 clear empties", done, 0);
    check("R9 clear word invalid", rd_word[15], 0);
    check("R9 clear rie", rie_o, 0);
    check("R9 clear sae", sae_o, 0);
    for (int i = 0; i < ALM; i++) push(8'(i), 3'd3, 1'b0, 1'b0, 1'b0);
    check("R9 alarm after clear", alarm, 1);
    check("R9 irq off after clear", irq, 0);
  endtask

  task automatic t_full();
    logic [15:0] w;
    do_clear();
    for (int i = 0; i < DEPTH; i++) push(8'(i), 3'(i), 1'b0, 1'b0, 1'b0);
    check("R10 no pulse when filling", ovf_pulse, 0);
    push(8'hEE, 3'd7, 1'b1, 1'b1, 1'b1);
    check("R10 drop pulse", ovf_pulse, 1);
    @(negedge clk);
    check("R10 pulse one cycle", ovf_pulse, 0);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(w);
      check("R10 R2 drain order", w, {8'h80 | 8'(i % 8), 8'(i)});
      settle_wait();
    end
    check("R10 drop not stored", rd_word[15], 0);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scan_en = 1'b0; clr = 1'b0;
    ctl_wr = 1'b0; ctl_rie = 1'b0; ctl_sae = 1'b0;
    wr_en = 1'b0; wr_char = '0; wr_line = '0;
    wr_perr = 1'b0; wr_ferr = 1'b0; wr_ovr = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    scan_en = 1'b1;
    @(negedge clk);
    t_layout();
    t_order_settle();
    t_irq_modes();
    t_alarm();
    t_scan();
    t_clear();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule